// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three 256-bit vector sets for one processor: vectors waiting for service (pending), vectors being serviced (in-service) and the trigger kind of each vector (edge or level). Requests arrive as a vector number with a level flag. A software-written task priority, together with the highest vector already in service, forms a processor priority. Only a pending vector whose upper nibble (its priority class) beats that processor priority is offered on the interrupt line. Among pending vectors, the numerically highest one always wins.

When the processor acknowledges, an eligible vector moves from pending to in-service and is returned. If the winner is blocked by processor priority, the controller returns the programmable spurious vector and leaves all state untouched. Writing the end-of-interrupt index retires the highest in-service vector. For a level-triggered vector, the block also sends out a one-cycle broadcast carrying that vector, unless directed end-of-interrupt is selected. Software reaches all state through a word-indexed register port. A wrong index is recorded in an error register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the task priority reads 0x00, the spurious register reads 0x0FF (delivery disabled), processor priority and the error register read 0, all three vector sets are empty and irq_out is low.
- R2: A cycle with req_valid high sets the pending bit of req_vector and writes req_level into that vector's trigger bit (1 = level, 0 = edge); a request always sets its pending bit, even when an acknowledge clears the same vector in that cycle.
- R3: An acknowledge with an eligible vector clears the highest pending bit, sets the same in-service bit and, one cycle later, raises ack_done and ack_hit with ack_vector equal to that vector; the highest vector number has priority.
- R4: Processor priority is the task priority when its class (bits 7:4) is at least the class of the highest in-service vector (an empty set counts as class 0), and otherwise that in-service class followed by 4'h0; it reads at index 0x0A.
- R5: If processor priority is nonzero and the highest pending class is at or below its class, an acknowledge returns ack_hit = 1 with the low 8 bits of the spurious register and changes no state; with nothing pending it returns ack_hit = 0 and ack_vector = 0.
- R6: A write to index 0x0B clears the highest in-service bit; one cycle later eoi_bc_valid pulses with that vector when its trigger bit is 1 and spurious bit 12 (directed end-of-interrupt) is 0; with an empty in-service set the write changes nothing.
- R7: While spurious bit 8 (software enable) is 0, irq_out stays low and an acknowledge returns ack_hit = 0 without changing any state.
- R8: irq_out is registered: it equals, one cycle late, whether delivery is enabled and an eligible pending vector exists.
- R9: When an acknowledge and an end-of-interrupt write share a cycle, the retirement is applied first and the acknowledge is judged against the reduced in-service set.
- R10: Register index map: 0x08 task priority (read/write, 8 bits), 0x0A processor priority, 0x10+w in-service word w, 0x18+w trigger word w, 0x20+w pending word w (word w holds vectors 32w..32w+31, bit n = vector 32w+n), 0x28 error register; writes to read-only indices change nothing and read data appears on reg_rdata the cycle after reg_rd.
- R11: A write to the spurious index 0x0F keeps bits 8:0 and bit 12; all other bits read back as 0.
- R12: A read or write of any index not in the map sets bit 7 of the error register (sticky until reset), and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_done | output | 1 | Acknowledge response valid (one cycle after ack) |
| ack_hit | output | 1 | A vector is returned |
| ack_vector | output | 8 | Returned vector, 0 when ack_hit is low |
| irq_out | output | 1 | Interrupt pending towards the processor |
| eoi_bc_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vector | output | 8 | Vector carried by the broadcast |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 8 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |

## Verification
An acknowledge and an end-of-interrupt write can arrive in the same cycle. The ordering between them decides whether a pending vector blocked by the vector being retired is delivered or answered with the spurious vector. The bench puts a high vector in service, confirms that a lower pending vector is refused, then asserts ack and the end-of-interrupt write together. It expects the lower vector to be delivered, and for a level-triggered retiree it also expects the broadcast pulse in the same response cycle. The expected outcome comes from a bench-side model of the three sets that applies the retirement before judging the acknowledge.

// File: rtl/irq_prio_pkg.sv
// Shared constants and types for the vectored interrupt priority controller.
// Assumes an 8-bit vector space and a 32-bit register data path.
package irq_prio_pkg;
    localparam int VEC_W           = 8;
    localparam int REG_W           = 32;
    localparam int IDX_W           = 8;
    localparam int SPUR_W          = 13;
    localparam int SPUR_EN_BIT     = 8;
    localparam int SPUR_DEOI_BIT   = 12;
    localparam int ERR_W           = 8;
    localparam int ERR_ILLEGAL_BIT = 7;

    localparam logic [IDX_W-1:0] IDX_TPR  = 8'h08;
    localparam logic [IDX_W-1:0] IDX_PPR  = 8'h0A;
    localparam logic [IDX_W-1:0] IDX_EOI  = 8'h0B;
    localparam logic [IDX_W-1:0] IDX_SPUR = 8'h0F;
    localparam logic [IDX_W-1:0] IDX_ISR0 = 8'h10;
    localparam logic [IDX_W-1:0] IDX_TMR0 = 8'h18;
    localparam logic [IDX_W-1:0] IDX_IRR0 = 8'h20;
    localparam logic [IDX_W-1:0] IDX_ERR  = 8'h28;

    // Result of a highest-set-bit search over a vector set.
    typedef struct packed {
        logic             found;
        logic [VEC_W-1:0] vec;
    } vec_pick_t;
endpackage

// File: rtl/irq_prio_msb.sv
// Highest-set-bit finder over a vector set.
// Two levels: a per-word search and a word select, so the depth grows with
// log of the word width plus log of the word count rather than the set size.
// Assumes NUM_VEC is a multiple of WORD_W with at least two words.
module irq_prio_msb
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic [NUM_VEC-1:0] bits,
    output vec_pick_t          pick
);
    localparam int NWORDS = NUM_VEC / WORD_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WSEL_W = $clog2(NWORDS);

    logic [NWORDS-1:0] word_any;
    logic [BIT_W-1:0]  word_top [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [BIT_W-1:0] top_b;
        // Find the highest set bit inside one word.
        always_comb begin
            top_b = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[g*WORD_W + b]) top_b = BIT_W'(b);
            end
        end
        assign word_any[g] = |bits[g*WORD_W +: WORD_W];
        assign word_top[g] = top_b;
    end

    logic [WSEL_W-1:0] sel;
    // Pick the highest non-empty word and join word and bit numbers.
    always_comb begin
        sel = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) sel = WSEL_W'(w);
        end
        pick.found = |word_any;
        pick.vec   = VEC_W'({sel, word_top[sel]});
    end
endmodule

// File: rtl/irq_prio_arb.sv
// Priority judge: derives processor priority from task priority and the
// highest in-service class, finds the highest pending vector and decides
// whether it may be delivered. Purely combinational.
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] serv,
    input  logic [VEC_W-1:0]   tpr,
    output logic [VEC_W-1:0]   ppr,
    output vec_pick_t          top_pend,
    output logic               eligible
);
    vec_pick_t  serv_pick;
    logic [3:0] serv_class;

    irq_prio_msb #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_pend_pick (
        .bits (pend),
        .pick (top_pend)
    );

    irq_prio_msb #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_serv_pick (
        .bits (serv),
        .pick (serv_pick)
    );

    // Processor priority and the low-priority test on the pending winner.
    always_comb begin
        serv_class = serv_pick.found ? serv_pick.vec[7:4] : 4'h0;
        ppr        = (tpr[7:4] >= serv_class) ? tpr : {serv_class, 4'h0};
        eligible   = top_pend.found &&
                     !((ppr != '0) && (top_pend.vec[7:4] <= ppr[7:4]));
    end
endmodule

// File: rtl/irq_prio_regif.sv
// Word-indexed register port: decodes write strobes, builds read data one
// cycle after a read strobe and keeps the sticky error register.
// Assumes at most eight words per set so the index map does not overlap.
module irq_prio_regif
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [VEC_W-1:0]   tpr,
    input  logic [VEC_W-1:0]   ppr,
    input  logic [SPUR_W-1:0]  spur,
    input  logic [NUM_VEC-1:0] isr,
    input  logic [NUM_VEC-1:0] tmr,
    input  logic [NUM_VEC-1:0] irr,
    output logic               wr_tpr,
    output logic               wr_spur,
    output logic               wr_eoi,
    output logic [REG_W-1:0]   reg_rdata
);
    localparam int NWORDS = NUM_VEC / WORD_W;
    localparam int WSEL_W = $clog2(NWORDS);

    logic [WORD_W-1:0] isr_w [NWORDS];
    logic [WORD_W-1:0] tmr_w [NWORDS];
    logic [WORD_W-1:0] irr_w [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_words
        assign isr_w[g] = isr[g*WORD_W +: WORD_W];
        assign tmr_w[g] = tmr[g*WORD_W +: WORD_W];
        assign irr_w[g] = irr[g*WORD_W +: WORD_W];
    end

    logic [ERR_W-1:0]  err_q;
    logic [REG_W-1:0]  rd_val;
    logic              illegal;
    logic [WSEL_W-1:0] wsel_isr, wsel_tmr, wsel_irr;

    // Read multiplexer and legality decode for the current index.
    always_comb begin
        rd_val   = '0;
        illegal  = 1'b0;
        wsel_isr = WSEL_W'(reg_idx - IDX_ISR0);
        wsel_tmr = WSEL_W'(reg_idx - IDX_TMR0);
        wsel_irr = WSEL_W'(reg_idx - IDX_IRR0);
        if (reg_idx == IDX_TPR)       rd_val = REG_W'(tpr);
        else if (reg_idx == IDX_PPR)  rd_val = REG_W'(ppr);
        else if (reg_idx == IDX_EOI)  rd_val = '0;
        else if (reg_idx == IDX_SPUR) rd_val = REG_W'(spur);
        else if (reg_idx == IDX_ERR)  rd_val = REG_W'(err_q);
        else if (reg_idx >= IDX_ISR0 && reg_idx < IDX_ISR0 + IDX_W'(NWORDS))
            rd_val = REG_W'(isr_w[wsel_isr]);
        else if (reg_idx >= IDX_TMR0 && reg_idx < IDX_TMR0 + IDX_W'(NWORDS))
            rd_val = REG_W'(tmr_w[wsel_tmr]);
        else if (reg_idx >= IDX_IRR0 && reg_idx < IDX_IRR0 + IDX_W'(NWORDS))
            rd_val = REG_W'(irr_w[wsel_irr]);
        else
            illegal = 1'b1;
    end

    assign wr_tpr  = reg_wr && (reg_idx == IDX_TPR);
    assign wr_spur = reg_wr && (reg_idx == IDX_SPUR);
    assign wr_eoi  = reg_wr && (reg_idx == IDX_EOI);

    // Registered read data and sticky illegal-index flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            err_q     <= '0;
        end else begin
            reg_rdata <= reg_rd ? (illegal ? '0 : rd_val) : '0;
            if ((reg_rd || reg_wr) && illegal) err_q[ERR_ILLEGAL_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Vectored interrupt priority controller top.
// Holds pending, in-service and trigger sets, task priority and the
// spurious register; answers acknowledges, retires vectors on
// end-of-interrupt and drives a registered interrupt line.
// Assumes req/ack/register strobes are single-cycle and synchronous to clk.
// Same-cycle ordering: end-of-interrupt retirement, then acknowledge.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic              ack,
    output logic              ack_done,
    output logic              ack_hit,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              irq_out,
    output logic              eoi_bc_valid,
    output logic [VEC_W-1:0]  eoi_bc_vector,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [VEC_W-1:0]   tpr_q;
    logic [SPUR_W-1:0]  spur_q;
    logic               sw_en;

    logic wr_tpr, wr_spur, wr_eoi;
    logic wdata_unused;
    assign wdata_unused = ^{reg_wdata[REG_W-1:SPUR_W], reg_wdata[SPUR_DEOI_BIT-1:SPUR_EN_BIT+1]};

    assign sw_en = spur_q[SPUR_EN_BIT];

    // End-of-interrupt: retire the highest in-service vector.
    vec_pick_t          eoi_pick;
    logic               eoi_fire;
    logic [NUM_VEC-1:0] eoi_mask, isr_eff;

    irq_prio_msb #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_eoi_pick (
        .bits (isr_q),
        .pick (eoi_pick)
    );

    assign eoi_fire = wr_eoi && eoi_pick.found;
    assign eoi_mask = eoi_fire ? (NUM_VEC'(1) << eoi_pick.vec) : '0;
    assign isr_eff  = isr_q & ~eoi_mask;

    // Acknowledge judge, seeing the in-service set after retirement.
    vec_pick_t        ack_pick;
    logic             ack_elig;
    logic [VEC_W-1:0] ack_ppr_unused;

    irq_prio_arb #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_arb_ack (
        .pend     (irr_q),
        .serv     (isr_eff),
        .tpr      (tpr_q),
        .ppr      (ack_ppr_unused),
        .top_pend (ack_pick),
        .eligible (ack_elig)
    );

    // State judge for the interrupt line and the priority readout.
    vec_pick_t        now_pick_unused;
    logic             now_elig;
    logic [VEC_W-1:0] ppr_now;

    irq_prio_arb #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_arb_now (
        .pend     (irr_q),
        .serv     (isr_q),
        .tpr      (tpr_q),
        .ppr      (ppr_now),
        .top_pend (now_pick_unused),
        .eligible (now_elig)
    );

    irq_prio_regif #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_idx   (reg_idx),
        .tpr       (tpr_q),
        .ppr       (ppr_now),
        .spur      (spur_q),
        .isr       (isr_q),
        .tmr       (tmr_q),
        .irr       (irr_q),
        .wr_tpr    (wr_tpr),
        .wr_spur   (wr_spur),
        .wr_eoi    (wr_eoi),
        .reg_rdata (reg_rdata)
    );

    logic               ack_take;
    logic [NUM_VEC-1:0] ack_mask, req_mask;

    assign ack_take = ack && sw_en && ack_elig;
    assign ack_mask = ack_take ? (NUM_VEC'(1) << ack_pick.vec) : '0;
    assign req_mask = req_valid ? (NUM_VEC'(1) << req_vector) : '0;

    // Software-visible control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q  <= '0;
            spur_q <= SPUR_W'(12'h0FF);
        end else begin
            if (wr_tpr)  tpr_q  <= reg_wdata[VEC_W-1:0];
            if (wr_spur) spur_q <= {reg_wdata[SPUR_DEOI_BIT], 3'b000, reg_wdata[SPUR_EN_BIT:0]};
        end
    end

    // Pending, in-service and trigger sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~ack_mask) | req_mask;
            isr_q <= isr_eff | ack_mask;
            if (req_valid) tmr_q[req_vector] <= req_level;
        end
    end

    // Acknowledge response, broadcast pulse and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done      <= 1'b0;
            ack_hit       <= 1'b0;
            ack_vector    <= '0;
            eoi_bc_valid  <= 1'b0;
            eoi_bc_vector <= '0;
            irq_out       <= 1'b0;
        end else begin
            ack_done   <= ack;
            ack_hit    <= ack && sw_en && ack_pick.found;
            ack_vector <= (ack && sw_en && ack_pick.found)
                          ? (ack_elig ? ack_pick.vec : spur_q[VEC_W-1:0]) : '0;
            eoi_bc_valid  <= eoi_fire && tmr_q[eoi_pick.vec] && !spur_q[SPUR_DEOI_BIT];
            eoi_bc_vector <= eoi_fire ? eoi_pick.vec : '0;
            irq_out       <= sw_en && now_elig;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Property checker for irq_prio_ctrl, attached with bind below.
// Assumes synchronous active-low reset; all properties are off in reset.
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vector,
    input logic               req_level,
    input logic               ack_hit,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               irq_out,
    input logic               eoi_bc_valid,
    input logic [VEC_W-1:0]   eoi_bc_vector,
    input logic               reg_wr,
    input logic [IDX_W-1:0]   reg_idx,
    input logic [NUM_VEC-1:0] irr,
    input logic [NUM_VEC-1:0] isr,
    input logic [NUM_VEC-1:0] tmr,
    input logic               sw_en
);
    a_r2_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> irr[$past(req_vector)]);

    a_r2_trigger_kind: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (tmr[$past(req_vector)] == $past(req_level)));

    a_r6_bcast_needs_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> $past(reg_wr && (reg_idx == IDX_EOI)));

    a_r6_bcast_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_bc_valid && !(ack_hit && (ack_vector == eoi_bc_vector))) |-> !isr[eoi_bc_vector]);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> !irq_out);

    a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|irr));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vector    (req_vector),
    .req_level     (req_level),
    .ack_hit       (ack_hit),
    .ack_vector    (ack_vector),
    .irq_out       (irq_out),
    .eoi_bc_valid  (eoi_bc_valid),
    .eoi_bc_vector (eoi_bc_vector),
    .reg_wr        (reg_wr),
    .reg_idx       (reg_idx),
    .irr           (irr_q),
    .isr           (isr_q),
    .tmr           (tmr_q),
    .sw_en         (sw_en)
);

// File: tb/irq_prio_ctrl_test.sv
// Self-checking bench: keeps its own model of the three vector sets and the
// control registers, sweeps all vectors and all task/vector class pairs.
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        ack = 1'b0;
    logic        ack_done, ack_hit, irq_out, eoi_bc_valid;
    logic [7:0]  ack_vector, eoi_bc_vector;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #10 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .ack(ack), .ack_done(ack_done), .ack_hit(ack_hit), .ack_vector(ack_vector),
        .irq_out(irq_out), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    bit [7:0]   m_tpr = '0;
    bit [12:0]  m_spur = 13'h0FF;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic int top_of(input bit [255:0] s);
        for (int i = 255; i >= 0; i--) if (s[i]) return i;
        return -1;
    endfunction

    function automatic int ppr_m();
        int t = top_of(m_isr);
        int sc = (t < 0) ? 0 : (t >> 4);
        return ((m_tpr >> 4) >= sc) ? int'(m_tpr) : (sc << 4);
    endfunction

    function automatic bit elig_m();
        int hp = top_of(m_irr);
        int p = ppr_m();
        if (hp < 0) return 1'b0;
        return !((p != 0) && ((hp >> 4) <= (p >> 4)));
    endfunction

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
        reg_rd = 1'b1; reg_idx = idx;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic request(input int v, input bit lvl);
        req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        m_irr[v] = 1'b1;
        m_tmr[v] = lvl;
    endtask

    // One cycle with acknowledge and/or end-of-interrupt; retirement first (R9).
    task automatic op(input bit do_ack, input bit do_eoi, input string tag);
        bit ebc = 1'b0; int ebv = 0; bit ehit = 1'b0; int evec = 0;
        if (do_eoi) begin
            int t = top_of(m_isr);
            if (t >= 0) begin
                m_isr[t] = 1'b0;
                ebc = m_tmr[t] && !m_spur[12];
                ebv = t;
            end
        end
        if (do_ack && m_spur[8]) begin
            int hp = top_of(m_irr);
            if (hp >= 0) begin
                ehit = 1'b1;
                if (elig_m()) begin
                    evec = hp; m_irr[hp] = 1'b0; m_isr[hp] = 1'b1;
                end else evec = int'(m_spur[7:0]);
            end
        end
        ack = do_ack; reg_wr = do_eoi; reg_idx = 8'h0B;
        @(negedge clk);
        ack = 1'b0; reg_wr = 1'b0;
        if (do_ack) begin
            check({tag, " ack_done"}, 32'(ack_done), 32'(1));
            check({tag, " ack_hit"}, 32'(ack_hit), 32'(ehit));
            check({tag, " ack_vector"}, 32'(ack_vector), 32'(evec));
        end
        if (do_eoi) begin
            check({tag, " eoi_bc_valid"}, 32'(eoi_bc_valid), 32'(ebc));
            if (ebc) check({tag, " eoi_bc_vector"}, 32'(eoi_bc_vector), 32'(ebv));
        end
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk);
        check({tag, " irq_out"}, 32'(irq_out), 32'(m_spur[8] && elig_m()));
    endtask

    task automatic set_spur(input logic [31:0] d);
        reg_write(8'h0F, d);
        m_spur = {d[12], 3'b000, d[8:0]};
    endtask

    task automatic set_tpr(input logic [7:0] d);
        reg_write(8'h08, 32'(d));
        m_tpr = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 irq_out", 32'(irq_out), 0);
        reg_read(8'h08, rd); check("R1 task priority", rd, 32'h0);
        reg_read(8'h0F, rd); check("R1 spurious", rd, 32'h0FF);
        reg_read(8'h0A, rd); check("R1 proc priority", rd, 32'h0);
        reg_read(8'h28, rd); check("R1 error reg", rd, 32'h0);
        for (int w = 0; w < 8; w++) begin
            reg_read(8'(8'h20 + w), rd); check("R1 pending word", rd, 32'h0);
            reg_read(8'(8'h10 + w), rd); check("R1 in-service word", rd, 32'h0);
        end

        // R7: disabled delivery holds the line low and ack returns nothing
        request(8'h40, 1'b0);
        check_irq("R7 disabled");
        op(1'b1, 1'b0, "R7 disabled ack");
        reg_read(8'h22, rd); check("R7 pending kept", rd, m_irr[64 +: 32]);
        set_spur(32'h1FF);
        check_irq("R8 enabled");
        op(1'b1, 1'b0, "R3 after enable");
        op(1'b0, 1'b1, "R6 retire");

        // R11: spurious write keeps bits 8:0 and 12
        reg_write(8'h0F, 32'hFFFF_FFFF);
        reg_read(8'h0F, rd); check("R11 spurious mask", rd, 32'h11FF);
        set_spur(32'h1FF);

        // R2 R3 R6 R8 R10: every vector, trigger kind alternating
        for (int v = 0; v < 256; v++) begin
            bit lvl = v[0];
            request(v, lvl);
            reg_read(8'(8'h20 + v / 32), rd); check("R2 R10 pending word", rd, m_irr[(v/32)*32 +: 32]);
            reg_read(8'(8'h18 + v / 32), rd); check("R2 R10 trigger word", rd, m_tmr[(v/32)*32 +: 32]);
            check_irq("R8 after request");
            op(1'b1, 1'b0, "R3 sweep");
            reg_read(8'(8'h10 + v / 32), rd); check("R3 R10 in-service word", rd, m_isr[(v/32)*32 +: 32]);
            op(1'b0, 1'b1, "R6 sweep");
            check_irq("R8 after retire");
        end

        // R4 R5: every task-priority class against every vector class
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                set_tpr(8'((t << 4) | 3));
                reg_read(8'h0A, rd); check("R4 ppr from tpr", rd, 32'(ppr_m()));
                request((c << 4) | 5, 1'b0);
                op(1'b1, 1'b0, "R5 class judge");
                if (m_irr[(c << 4) | 5]) begin
                    set_tpr(8'h00);
                    op(1'b1, 1'b0, "R3 drain");
                end
                op(1'b0, 1'b1, "R6 drain");
            end
        end
        set_tpr(8'h00);

        // R4 R5: in-service class gates a lower request
        request(8'h50, 1'b0);
        op(1'b1, 1'b0, "R3 take 0x50");
        reg_read(8'h0A, rd); check("R4 ppr from in-service", rd, 32'h50);
        request(8'h45, 1'b0);
        check_irq("R8 blocked");
        op(1'b1, 1'b0, "R5 blocked by in-service");
        request(8'h65, 1'b0);
        op(1'b1, 1'b0, "R3 higher class passes");
        op(1'b0, 1'b1, "R6 retire 0x65");
        op(1'b0, 1'b1, "R6 retire 0x50");
        op(1'b1, 1'b0, "R3 take 0x45");
        op(1'b0, 1'b1, "R6 retire 0x45");

        // R9: acknowledge and retirement in the same cycle
        request(8'h80, 1'b1);
        op(1'b1, 1'b0, "R3 take 0x80");
        request(8'h75, 1'b0);
        op(1'b1, 1'b0, "R5 0x75 blocked");
        op(1'b1, 1'b1, "R9 eoi then ack");
        check("R9 delivered 0x75", 32'(ack_vector), 32'h75);
        op(1'b0, 1'b1, "R6 retire 0x75");

        // R3 R5: several pending, served highest first with class blocking
        request(8'h21, 1'b0); request(8'h9A, 1'b1);
        request(8'h64, 1'b0); request(8'h9B, 1'b0);
        for (int k = 0; k < 6; k++) begin
            op(1'b1, 1'b0, "R3 R5 ordered ack");
            op(1'b0, 1'b1, "R6 ordered retire");
        end

        // R6: directed end-of-interrupt suppresses the broadcast
        set_spur(32'h11FF);
        request(8'h33, 1'b1);
        op(1'b1, 1'b0, "R3 take 0x33");
        op(1'b0, 1'b1, "R6 directed no broadcast");
        set_spur(32'h1FF);

        // R6: retirement with an empty in-service set does nothing
        op(1'b0, 1'b1, "R6 empty retire");
        reg_read(8'h10, rd); check("R6 empty in-service", rd, 32'h0);

        // R10: read-only indices ignore writes
        request(8'h02, 1'b0);
        op(1'b1, 1'b0, "R3 take 0x02");
        reg_write(8'h10, 32'hFFFF_FFFF);
        reg_write(8'h0A, 32'hFFFF_FFFF);
        reg_read(8'h10, rd); check("R10 in-service read-only", rd, m_isr[31:0]);
        reg_read(8'h0A, rd); check("R10 ppr read-only", rd, 32'(ppr_m()));
        reg_read(8'h28, rd); check("R12 no error on mapped index", rd, 32'h0);
        op(1'b0, 1'b1, "R6 retire 0x02");

        // R12: unmapped index
        reg_read(8'h05, rd); check("R12 unmapped read data", rd, 32'h0);
        reg_read(8'h28, rd); check("R12 error bit after read", rd, 32'h80);
        reg_write(8'h40, 32'h1234);
        reg_read(8'h28, rd); check("R12 error bit sticky", rd, 32'h80);
        reg_read(8'h0F, rd); check("R12 spurious untouched", rd, 32'h1FF);

        summary();
        $finish;
    end
endmodule